// File: doc/BRIEF.md
# Registered 32-bit integer ALU with bit-manipulation operations

This execution unit takes an opcode, two 32-bit operands A and B and the current condition-flags word. It returns a registered 32-bit result one clock later, together with a valid strobe. It covers the usual add, subtract and bitwise operations. It also covers a set of special operations:

- shifts whose count saturates,
- a bit test that produces a new flags word,
- a restoring division step,
- an unsigned upper bound,
- a leading-zero count,
- half-word and byte swaps,
- a bit reversal inside each byte,
- a signed absolute value,
- signed and unsigned 32x32 multiplies.

A multiply also loads the upper 32 bits of its 64-bit product into a separate high-word register. That register is visible on its own output and keeps its value until the next accepted multiply.

The pipeline that feeds this unit presents one operation per cycle with `in_valid` high. The unit computes the result in one combinational stage and captures it in the output register at the next rising clock edge. When `in_valid` is low, the result register and the high-word register keep their values. The opcode is 5 bits wide. Each requirement below gives the opcode codes it uses, and every code not listed there is treated as unknown.

Top module: `bitalu_core`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `res`, `hi_word` and `out_valid` are cleared to zero by that edge.
- R2: `out_valid` at each rising edge takes the value `in_valid` had before that edge. `res` is loaded only when `in_valid` is high and otherwise keeps its value.
- R3: Opcode 0 gives A+B, opcode 1 gives A-B, opcode 2 gives A AND B, opcode 3 gives A OR B and opcode 4 gives A XOR B. All of these wrap modulo 2^32.
- R4: Opcode 5 shifts A left, opcode 6 shifts A right logically and opcode 7 shifts A right arithmetically, all by B read as an unsigned 32-bit count. A count above 31 gives zero for opcodes 5 and 6. For opcode 7 it gives 32 copies of A[31].
- R5: Opcode 8 (bit test) selects the bit of A at position B[4:0]. Its result is the flags input with bit 4 cleared, bit 3 set to the selected bit, and bit 2 set exactly when the selected bit and all bits below it are zero. All other bits are unchanged.
- R6: Opcode 9 (division step) forms S = A shifted left by one. It returns S-B if S >= B unsigned, otherwise S.
- R7: Opcode 10 (bound) returns B when A > B unsigned, otherwise A.
- R8: Opcode 11 returns the number of leading zeros of B, and 32 when B is zero.
- R9: Opcode 12 exchanges the 16-bit halves of A. Opcode 13 exchanges the two bytes inside each 16-bit half of A. Opcode 14 reverses the bit order inside each byte of A.
- R10: Opcode 15 returns the absolute value of B read as signed. 0x80000000 maps to itself.
- R11: Opcode 16 (signed) and opcode 17 (unsigned) form the 64-bit product of A and B. The low 32 bits go to `res` and the high 32 bits go to `hi_word`, both at the same edge.
- R12: `hi_word` changes only at an edge where `in_valid` is high and the opcode is 16 or 17. Opcodes 18 to 31 give `res` zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 5 | Operation code |
| a | input | 32 | Operand A |
| b | input | 32 | Operand B (shift count, bit position, or the only operand for some operations) |
| flags_in | input | 32 | Current condition-flags word, used by the bit test |
| res | output | 32 | Registered result |
| hi_word | output | 32 | Upper half of the last accepted multiply product |
| out_valid | output | 1 | Result in `res` belongs to the previous cycle's operation |

## Verification
Every result of this unit, `res`, `hi_word` and `out_valid` alike, is due exactly one rising edge after the cycle that presents the operation. No operation takes longer, and the multiply has no extra stage. The bench changes inputs on the falling edge and compares all three outputs with its behavioural model on the next falling edge, so exactly one register stage lies between stimulus and sample. Cycles with `in_valid` low are compared the same way, which shows that the result and the high word hold their values. Directed vectors cover the shift saturation limits, both branches of the division step and the bound, the bit-test ends at bit 0 and bit 31, zero and top-bit inputs to the leading-zero count, the most negative value for the absolute value, and the extreme multiply products. A random run with unknown opcodes mixed in follows.

// File: rtl/bitalu_pkg.sv
// bitalu_pkg: opcode codes and flag bit positions shared by the ALU modules.
// Assumes a 5-bit opcode; codes not listed are treated as unknown.
package bitalu_pkg;
    localparam int OP_W  = 5;
    localparam int FLG_Z = 2;
    localparam int FLG_N = 3;
    localparam int FLG_X = 4;

    typedef enum logic [OP_W-1:0] {
        OPC_ADD   = 5'd0,
        OPC_SUB   = 5'd1,
        OPC_AND   = 5'd2,
        OPC_OR    = 5'd3,
        OPC_XOR   = 5'd4,
        OPC_SHL   = 5'd5,
        OPC_SHR   = 5'd6,
        OPC_SRA   = 5'd7,
        OPC_BTST  = 5'd8,
        OPC_DSTEP = 5'd9,
        OPC_BOUND = 5'd10,
        OPC_LZC   = 5'd11,
        OPC_SWPW  = 5'd12,
        OPC_SWPB  = 5'd13,
        OPC_BREV  = 5'd14,
        OPC_ABS   = 5'd15,
        OPC_MULS  = 5'd16,
        OPC_MULU  = 5'd17
    } alu_op_e;
endpackage

// File: rtl/bitalu_shift.sv
// bitalu_shift: the three shifts of A by the count in B.
// Any count of W or more saturates: logical shifts give zero and the
// arithmetic shift gives the sign bit replicated. Assumes W is a power of two.
module bitalu_shift #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y_shl,
    output logic [W-1:0] y_shr,
    output logic [W-1:0] y_sra
);
    localparam int SHW = $clog2(W);

    logic           big;
    logic [SHW-1:0] amt;

    // Split the count into an in-range amount and an overflow indication.
    assign big = |b[W-1:SHW];
    assign amt = b[SHW-1:0];

    // Pick either the shifted value or the saturated value.
    always_comb begin
        y_shl = big ? '0 : (a << amt);
        y_shr = big ? '0 : (a >> amt);
        y_sra = big ? {W{a[W-1]}} : W'($signed(a) >>> amt);
    end
endmodule

// File: rtl/bitalu_bitops.sv
// bitalu_bitops: the bit-level operations of the ALU.
// Covers the bit test with its flags word, the leading-zero count of B,
// the half-word swap, the byte swap inside each half, and the per-byte bit
// reversal of A. Assumes W is a multiple of 16 and a power of two.
module bitalu_bitops
    import bitalu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] flags_in,
    output logic [W-1:0] y_btst,
    output logic [W-1:0] y_lzc,
    output logic [W-1:0] y_swpw,
    output logic [W-1:0] y_swpb,
    output logic [W-1:0] y_brev
);
    localparam int SHW    = $clog2(W);
    localparam int NBYTES = W / 8;
    localparam int NHALF  = W / 16;
    localparam int HW     = W / 2;

    logic [SHW-1:0] sel;
    logic [W-1:0]   low_mask;
    logic           n_bit;
    logic           z_bit;
    logic [SHW:0]   lz_cnt;

    assign sel = b[SHW-1:0];

    // Mask of the selected bit and every bit below it.
    for (genvar i = 0; i < W; i++) begin : g_mask
        assign low_mask[i] = ((SHW+1)'(i) <= {1'b0, sel});
    end

    assign n_bit = a[sel];
    assign z_bit = ~|(a & low_mask);

    // Build the new flags word for the bit test.
    always_comb begin
        y_btst        = flags_in;
        y_btst[FLG_X] = 1'b0;
        y_btst[FLG_N] = n_bit;
        y_btst[FLG_Z] = z_bit;
    end

    // Count leading zeros of B; the highest set bit is the last one seen.
    always_comb begin
        lz_cnt = (SHW+1)'(W);
        for (int i = 0; i < W; i++) begin
            if (b[i]) lz_cnt = (SHW+1)'(W - 1 - i);
        end
    end
    assign y_lzc = W'(lz_cnt);

    assign y_swpw = {a[HW-1:0], a[W-1:HW]};

    // Swap the two bytes inside each 16-bit half.
    for (genvar h = 0; h < NHALF; h++) begin : g_half
        assign y_swpb[16*h +: 8]     = a[16*h + 8 +: 8];
        assign y_swpb[16*h + 8 +: 8] = a[16*h +: 8];
    end

    // Mirror bit j of every byte to bit 7-j of the same byte.
    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        for (genvar j = 0; j < 8; j++) begin : g_bit
            assign y_brev[8*k + j] = a[8*k + 7 - j];
        end
    end
endmodule

// File: rtl/bitalu_mul.sv
// bitalu_mul: full-width product of A and B, signed or unsigned.
// It is combinational; the caller registers the two halves.
module bitalu_mul #(
    parameter int W = 32
) (
    input  logic           is_signed,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] prod
);
    logic [2*W-1:0] ax;
    logic [2*W-1:0] bx;

    // Widen both operands; a two's-complement product wraps correctly.
    always_comb begin
        ax   = {{W{is_signed & a[W-1]}}, a};
        bx   = {{W{is_signed & b[W-1]}}, b};
        prod = ax * bx;
    end
endmodule

// File: rtl/bitalu_core.sv
// bitalu_core: registered integer ALU with bit-manipulation operations.
// One operation per cycle is accepted under in_valid. Its result appears
// in res one edge later, with out_valid high. Multiplies also load the
// product's upper half into hi_word. Reset is synchronous and active low.
module bitalu_core
    import bitalu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [W-1:0]    flags_in,
    output logic [W-1:0]    res,
    output logic [W-1:0]    hi_word,
    output logic            out_valid
);
    alu_op_e        opc;
    logic [W-1:0]   y_shl, y_shr, y_sra;
    logic [W-1:0]   y_btst, y_lzc, y_swpw, y_swpb, y_brev;
    logic [2*W-1:0] prod;
    logic [W-1:0]   dshift;
    logic [W-1:0]   res_d;
    logic           is_mul;

    assign opc = alu_op_e'(op);

    bitalu_shift #(.W(W)) i_shift (
        .a     (a),
        .b     (b),
        .y_shl (y_shl),
        .y_shr (y_shr),
        .y_sra (y_sra)
    );

    bitalu_bitops #(.W(W)) i_bitops (
        .a        (a),
        .b        (b),
        .flags_in (flags_in),
        .y_btst   (y_btst),
        .y_lzc    (y_lzc),
        .y_swpw   (y_swpw),
        .y_swpb   (y_swpb),
        .y_brev   (y_brev)
    );

    bitalu_mul #(.W(W)) i_mul (
        .is_signed (opc == OPC_MULS),
        .a         (a),
        .b         (b),
        .prod      (prod)
    );

    assign dshift = a << 1;
    assign is_mul = (opc == OPC_MULS) || (opc == OPC_MULU);

    // Select the result for the presented opcode; unknown codes give zero.
    always_comb begin
        case (opc)
            OPC_ADD:   res_d = a + b;
            OPC_SUB:   res_d = a - b;
            OPC_AND:   res_d = a & b;
            OPC_OR:    res_d = a | b;
            OPC_XOR:   res_d = a ^ b;
            OPC_SHL:   res_d = y_shl;
            OPC_SHR:   res_d = y_shr;
            OPC_SRA:   res_d = y_sra;
            OPC_BTST:  res_d = y_btst;
            OPC_DSTEP: res_d = (dshift >= b) ? dshift - b : dshift;
            OPC_BOUND: res_d = (a > b) ? b : a;
            OPC_LZC:   res_d = y_lzc;
            OPC_SWPW:  res_d = y_swpw;
            OPC_SWPB:  res_d = y_swpb;
            OPC_BREV:  res_d = y_brev;
            OPC_ABS:   res_d = b[W-1] ? (~b + 1'b1) : b;
            OPC_MULS,
            OPC_MULU:  res_d = prod[W-1:0];
            default:   res_d = '0;
        endcase
    end

    // Output registers: result, multiply high word and valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res       <= '0;
            hi_word   <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res <= res_d;
                if (is_mul) hi_word <= prod[2*W-1:W];
            end
        end
    end
endmodule

// File: rtl/bitalu_checker.sv
// bitalu_checker: temporal properties of bitalu_core, attached by bind.
// Relates the inputs of one cycle to the outputs after the next edge.
module bitalu_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [4:0]   op,
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic [W-1:0] res,
    input logic [W-1:0] hi_word,
    input logic         out_valid
);
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_no_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(res)));

    assert_bound_le_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 5'd10) |=> (res <= $past(a) && res <= $past(b)));

    assert_lzc_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 5'd11 && b == '0) |=> (res == W));

    assert_btst_x_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 5'd8) |=> (res[4] == 1'b0));

    assert_hi_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && (op == 5'd16 || op == 5'd17)) |=> $stable(hi_word));

    assert_unknown_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op > 5'd17) |=> (res == '0));
endmodule

bind bitalu_core bitalu_checker #(.W(W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .a         (a),
    .b         (b),
    .res       (res),
    .hi_word   (hi_word),
    .out_valid (out_valid)
);

// File: tb/test_bitalu_core.sv
// test_bitalu_core: behavioural reference model compared on every clock.
module test_bitalu_core;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  op = '0;
    logic [31:0] a = '0, b = '0, flags_in = '0;
    logic [31:0] res, hi_word;
    logic        out_valid;

    int checks = 0;
    int failures = 0;
    logic [31:0] m_res = '0, m_hi = '0;
    logic        m_vld = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitalu_core i_bitalu_core (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .a(a), .b(b), .flags_in(flags_in),
        .res(res), .hi_word(hi_word), .out_valid(out_valid)
    );

    function automatic string req_of(input logic [4:0] o);
        if (o <= 5'd4) return "R3";
        if (o <= 5'd7) return "R4";
        case (o)
            5'd8:  return "R5";
            5'd9:  return "R6";
            5'd10: return "R7";
            5'd11: return "R8";
            5'd12, 5'd13, 5'd14: return "R9";
            5'd15: return "R10";
            5'd16, 5'd17: return "R11";
            default: return "R12";
        endcase
    endfunction

    function automatic logic [31:0] model(input logic [4:0] o, input logic [31:0] x,
                                          input logic [31:0] y, input logic [31:0] f);
        logic [31:0] r;
        longint      sp;
        longint unsigned up;
        int          p;
        r = '0;
        case (o)
            5'd0:  r = x + y;
            5'd1:  r = x - y;
            5'd2:  r = x & y;
            5'd3:  r = x | y;
            5'd4:  r = x ^ y;
            5'd5:  r = (y > 32'd31) ? 32'd0 : x << y;
            5'd6:  r = (y > 32'd31) ? 32'd0 : x >> y;
            5'd7:  begin
                if (y > 32'd31) r = x[31] ? 32'hFFFF_FFFF : 32'd0;
                else            r = 32'($signed(x) >>> y);
            end
            5'd8:  begin
                p = int'(y[4:0]);
                r = f & ~32'h0000_001C;
                r[3] = x[p];
                r[2] = 1'b1;
                for (int i = 0; i <= p; i++) if (x[i]) r[2] = 1'b0;
            end
            5'd9:  begin
                r = {x[30:0], 1'b0};
                if (r >= y) r = r - y;
            end
            5'd10: r = (x > y) ? y : x;
            5'd11: begin
                r = 32;
                for (int i = 31; i >= 0; i--) if (y[i]) begin r = 31 - i; break; end
            end
            5'd12: r = {x[15:0], x[31:16]};
            5'd13: r = {x[23:16], x[31:24], x[7:0], x[15:8]};
            5'd14: for (int i = 0; i < 32; i++) r[(i/8)*8 + 7 - (i%8)] = x[i];
            5'd15: r = ($signed(x) < 0 || y[31]) ? (y[31] ? 32'(-y) : y) : y;
            5'd16: begin sp = longint'($signed(x)) * longint'($signed(y)); r = sp[31:0]; end
            5'd17: begin up = {32'd0, x} * {32'd0, y}; r = up[31:0]; end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic [31:0] model_hi(input logic [4:0] o, input logic [31:0] x,
                                             input logic [31:0] y);
        longint          sp;
        longint unsigned up;
        sp = longint'($signed(x)) * longint'($signed(y));
        up = {32'd0, x} * {32'd0, y};
        return (o == 5'd16) ? sp[63:32] : up[63:32];
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        check(out_valid === m_vld, "R2", "out_valid", {31'd0, out_valid}, {31'd0, m_vld});
        check(res === m_res, tag, "res", res, m_res);
        check(hi_word === m_hi, (tag == "R11") ? "R11" : "R12", "hi_word", hi_word, m_hi);
    endtask

    // Drive one cycle on the falling edge, then compare one edge later.
    task automatic step(input bit v, input logic [4:0] o, input logic [31:0] x,
                        input logic [31:0] y, input logic [31:0] f);
        string tag;
        in_valid = v; op = o; a = x; b = y; flags_in = f;
        tag = v ? req_of(o) : "R2";
        m_vld = v;
        if (v) begin
            m_res = model(o, x, y, f);
            if (o == 5'd16 || o == 5'd17) m_hi = model_hi(o, x, y);
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: outputs cleared while reset is held, even with an operation present.
        in_valid = 1'b1; op = 5'd17; a = 32'hFFFF_FFFF; b = 32'hFFFF_FFFF;
        repeat (3) begin
            @(negedge clk);
            check(res === 32'd0 && hi_word === 32'd0 && out_valid === 1'b0,
                  "R1", "reset state", res | hi_word | {31'd0, out_valid}, 32'd0);
        end
        rst_n = 1'b1;
        in_valid = 1'b0;
        step(0, 5'd0, 0, 0, 0);
        // R3 basic arithmetic and logic
        step(1, 5'd0, 32'hFFFF_FFFF, 32'd2, 0);
        step(1, 5'd1, 32'd3, 32'd5, 0);
        step(1, 5'd2, 32'hF0F0_1234, 32'h0FF0_FFFF, 0);
        step(1, 5'd3, 32'hF000_0000, 32'h0000_000F, 0);
        step(1, 5'd4, 32'hAAAA_5555, 32'hFFFF_0000, 0);
        // R4 shifts with saturation
        step(1, 5'd5, 32'h8000_0001, 32'd4, 0);
        step(1, 5'd5, 32'h0000_0001, 32'd31, 0);
        step(1, 5'd5, 32'h0000_0001, 32'd32, 0);
        step(1, 5'd6, 32'h8000_0000, 32'd31, 0);
        step(1, 5'd6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        step(1, 5'd7, 32'h8000_0000, 32'd40, 0);
        step(1, 5'd7, 32'h7FFF_FFFF, 32'd33, 0);
        step(1, 5'd7, 32'h8000_0010, 32'd4, 0);
        // R5 bit test at both ends, flags kept except X/N/Z
        step(1, 5'd8, 32'h8000_0000, 32'd31, 32'hFFFF_FFFF);
        step(1, 5'd8, 32'h0000_0000, 32'd0, 32'h0000_0013);
        step(1, 5'd8, 32'h0000_0010, 32'd3, 32'h0000_0008);
        step(1, 5'd8, 32'h0000_0010, 32'h0000_0024, 32'd0);
        // R6 division step, both branches
        step(1, 5'd9, 32'd5, 32'd7, 0);
        step(1, 5'd9, 32'd3, 32'd7, 0);
        step(1, 5'd9, 32'h8000_0001, 32'd1, 0);
        // R7 bound, both branches and unsigned compare
        step(1, 5'd10, 32'd9, 32'd4, 0);
        step(1, 5'd10, 32'd4, 32'd9, 0);
        step(1, 5'd10, 32'h8000_0000, 32'd1, 0);
        // R8 leading zeros
        step(1, 5'd11, 0, 32'd0, 0);
        step(1, 5'd11, 0, 32'd1, 0);
        step(1, 5'd11, 0, 32'h8000_0000, 0);
        step(1, 5'd11, 0, 32'h0001_F000, 0);
        // R9 swaps and per-byte reversal
        step(1, 5'd12, 32'h1234_5678, 0, 0);
        step(1, 5'd13, 32'h1234_5678, 0, 0);
        step(1, 5'd14, 32'h0180_F00F, 0, 0);
        // R10 absolute value
        step(1, 5'd15, 0, 32'hFFFF_FFFB, 0);
        step(1, 5'd15, 0, 32'h8000_0000, 0);
        step(1, 5'd15, 0, 32'd17, 0);
        // R11 multiplies
        step(1, 5'd17, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        step(1, 5'd16, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        step(1, 5'd16, 32'hFFFF_FFFD, 32'd5, 0);
        step(1, 5'd16, 32'h8000_0000, 32'h8000_0000, 0);
        // R12 high word holds on other ops and on idle multiply; unknown gives zero
        step(1, 5'd0, 32'd1, 32'd1, 0);
        step(0, 5'd17, 32'h1234_5678, 32'h9ABC_DEF0, 0);
        step(1, 5'd31, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        step(1, 5'd18, 32'h1, 32'h2, 0);
        // R2 idle cycles hold the result
        step(1, 5'd4, 32'h0F0F_0F0F, 32'h0000_FFFF, 0);
        step(0, 5'd0, 32'd7, 32'd9, 0);
        step(0, 5'd16, 32'd7, 32'd9, 0);
        // Random mix, all opcodes including unknown ones
        for (int n = 0; n < 2000; n++) begin
            logic [31:0] rb;
            rb = $urandom();
            if (n % 3 == 0) rb = rb & 32'h3F;
            step(($urandom() % 5) != 0, 5'($urandom()), $urandom(), rb, $urandom());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule